// File: doc/BRIEF.md
# Incrementing-Byte Link Self-Test Engine

This block is a built-in self-test source and sink for a parallel link datapath. The source side sends a stream of words whose byte lanes carry a counting pattern. Each word holds consecutive byte values, with the lowest byte in lane 0, and the count wraps from 0xFF back to 0x00. The words travel toward a transmit path. The sink side takes the words that come back through a loopback path, locks onto the pattern and compares every later word against it. It reports the result on two sticky status pins.

Both data interfaces are valid/ready streams. A word moves only in a cycle where valid and ready are both high. The source holds its word and its valid flag for as long as ready stays low, so back-pressure from the transmit side never loses or skips a value. The sink raises ready one cycle after its reset ends and never lowers it after that, so it never applies back-pressure.

The two sides have independent synchronous active-high resets, one for the transmit side and one for the receive side. The serializer, the line coding, word alignment and the loopback wiring all sit outside this block.

Top module: `incpat_bist`

## Requirements
- R1: Byte lane k of `gen_data` (bits 8k+7 down to 8k) equals the source base value plus k, modulo 256. The first word after `tx_rst` is 0x0100.
- R2: Each accepted source word (`gen_valid` and `gen_ready` both high) advances the base by 2, modulo 256. The word after 0xFFFE is therefore 0x0100. While `gen_ready` is low, `gen_data` holds its value.
- R3: A sink word presented with `chk_valid` low has no effect on `chk_err`, on `chk_done` or on the expected sequence.
- R4: Before it locks, the sink discards words whose lanes are not consecutive (lane 1 is not lane 0 plus 1), and these words raise no error. The first valid word with consecutive lanes seeds the expected value. The next expected word is that seed plus 2 per lane.
- R5: After the sink locks, a valid word that differs from the expected word sets both `chk_err` and `chk_done` on the next clock edge.
- R6: Once the sink has matched 128 words without error, `chk_done` rises on the edge that accepts the 128th word, and `chk_err` stays low. The seed word counts as the first of the 128.
- R7: `chk_err` and `chk_done` are sticky. After an error the sink stops comparing, and later words change neither flag.
- R8: `rx_rst` clears both flags and returns the sink to its unlocked state. `tx_rst` restarts the source and leaves both flags unchanged.
- R9: `gen_valid` is low while `tx_rst` is high and `chk_ready` is low while `rx_rst` is high. Each goes high on the first clock edge after its reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| tx_rst | input | 1 | Synchronous reset for the source, active high |
| rx_rst | input | 1 | Synchronous reset for the sink, active high |
| gen_valid | output | 1 | Source word valid |
| gen_ready | input | 1 | Transmit side accepts the source word |
| gen_data | output | 16 | Source word, two consecutive byte values |
| chk_valid | input | 1 | Sink word valid |
| chk_ready | output | 1 | Sink accepts words |
| chk_data | input | 16 | Word returned through the loopback |
| chk_err | output | 1 | Sticky flag: a mismatch was detected |
| chk_done | output | 1 | Sticky flag: a full cycle was matched, or an error was detected |

## Verification
The hardest case to reach through the ports is the exact cycle-count boundary of R6. It needs a locked sink that has passed through the 0xFF to 0x00 wrap without a single false mismatch. The bench reaches it by driving the sink directly. It starts from a seed in the middle of the range, sends exactly 127 matching words and checks that `chk_done` is still low, then sends the 128th word. Error freezing and the independence of the two resets are reached in the looped mode. There, a configurable-latency pipe carries the source output into the sink, and the bench either flips one data bit in flight or resets only the transmit side while the sink is locked.

// File: rtl/incpat_pkg.sv
package incpat_pkg;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_LANES  = 2;

  typedef enum logic [1:0] {
    CHK_HUNT = 2'd0,
    CHK_TRACK = 2'd1,
    CHK_FROZEN = 2'd2
  } chk_state_e;
endpackage

// File: rtl/incpat_lanes.sv
// Expands a base byte into a word of consecutive byte values, lane 0 lowest.
module incpat_lanes #(
  parameter int unsigned BYTE_W = incpat_pkg::DEF_BYTE_W,
  parameter int unsigned LANES  = incpat_pkg::DEF_LANES,
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic [BYTE_W-1:0] base,
  output logic [WORD_W-1:0] word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word[k*BYTE_W +: BYTE_W] = base + BYTE_W'(k);
  end
endmodule

// File: rtl/incpat_gen.sv
module incpat_gen #(
  parameter int unsigned BYTE_W = incpat_pkg::DEF_BYTE_W,
  parameter int unsigned LANES  = incpat_pkg::DEF_LANES,
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [BYTE_W-1:0] base_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      if (valid_q && out_ready) base_q <= base_q + BYTE_W'(LANES);
    end
  end

  incpat_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) u_expand (
    .base(base_q),
    .word(out_data)
  );

  assign out_valid = valid_q;
endmodule

// File: rtl/incpat_chk.sv
module incpat_chk #(
  parameter int unsigned BYTE_W = incpat_pkg::DEF_BYTE_W,
  parameter int unsigned LANES  = incpat_pkg::DEF_LANES,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned CYCLE_WORDS = (1 << BYTE_W) / LANES,
  localparam int unsigned CNT_W = $clog2(CYCLE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              err,
  output logic              done
);
  import incpat_pkg::*;

  chk_state_e        state_q;
  logic [BYTE_W-1:0] exp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ready_q, err_q, done_q;
  logic [WORD_W-1:0] exp_word, seed_word;
  logic [BYTE_W-1:0] rx_lane0;
  logic              take, seed_ok, match;

  assign rx_lane0 = in_data[BYTE_W-1:0];

  // Word rebuilt from the received lane 0: equal to the input only if lanes count up.
  incpat_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) u_seed (
    .base(rx_lane0),
    .word(seed_word)
  );

  incpat_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) u_expect (
    .base(exp_q),
    .word(exp_word)
  );

  assign take    = in_valid && ready_q;
  assign seed_ok = (seed_word == in_data);
  assign match   = (exp_word == in_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CHK_HUNT;
      exp_q   <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (take) begin
        unique case (state_q)
          CHK_HUNT: begin
            if (seed_ok) begin
              state_q <= CHK_TRACK;
              exp_q   <= rx_lane0 + BYTE_W'(LANES);
              cnt_q   <= CNT_W'(1);
              if (CYCLE_WORDS == 1) done_q <= 1'b1;
            end
          end
          CHK_TRACK: begin
            if (!match) begin
              state_q <= CHK_FROZEN;
              err_q   <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              exp_q <= exp_q + BYTE_W'(LANES);
              if (cnt_q != CNT_W'(CYCLE_WORDS)) cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(CYCLE_WORDS - 1)) done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign in_ready = ready_q;
  assign err      = err_q;
  assign done     = done_q;
endmodule

// File: rtl/incpat_bist.sv
module incpat_bist #(
  parameter int unsigned BYTE_W = incpat_pkg::DEF_BYTE_W,
  parameter int unsigned LANES  = incpat_pkg::DEF_LANES,
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              tx_rst,
  input  logic              rx_rst,
  output logic              gen_valid,
  input  logic              gen_ready,
  output logic [WORD_W-1:0] gen_data,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [WORD_W-1:0] chk_data,
  output logic              chk_err,
  output logic              chk_done
);
  incpat_gen #(.BYTE_W(BYTE_W), .LANES(LANES)) u_gen (
    .clk(clk),
    .rst(tx_rst),
    .out_valid(gen_valid),
    .out_ready(gen_ready),
    .out_data(gen_data)
  );

  incpat_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk(clk),
    .rst(rx_rst),
    .in_valid(chk_valid),
    .in_ready(chk_ready),
    .in_data(chk_data),
    .err(chk_err),
    .done(chk_done)
  );
endmodule

// File: rtl/incpat_bist_sva.sv
module incpat_bist_sva #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned WORD_W = BYTE_W * LANES
) (
  input logic              clk,
  input logic              tx_rst,
  input logic              rx_rst,
  input logic              gen_valid,
  input logic              gen_ready,
  input logic [WORD_W-1:0] gen_data,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic [WORD_W-1:0] chk_data,
  input logic              chk_err,
  input logic              chk_done
);
  if (LANES > 1) begin : g_lanes
    assert_lanes_count_R1: assert property (@(posedge clk) disable iff (tx_rst)
      gen_valid |-> gen_data[2*BYTE_W-1:BYTE_W] == gen_data[BYTE_W-1:0] + BYTE_W'(1));
  end

  assert_base_step_R2: assert property (@(posedge clk) disable iff (tx_rst)
    (gen_valid && gen_ready) |=> gen_data[BYTE_W-1:0] == $past(gen_data[BYTE_W-1:0]) + BYTE_W'(LANES));

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (tx_rst)
    (gen_valid && !gen_ready) |=> $stable(gen_data) && gen_valid);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rx_rst)
    chk_err |=> chk_err);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rx_rst)
    chk_done |=> chk_done);

  assert_err_implies_done_R5: assert property (@(posedge clk) disable iff (rx_rst)
    chk_err |-> chk_done);

  assert_rx_reset_clears_R8: assert property (@(posedge clk)
    rx_rst |=> !chk_err && !chk_done && !chk_ready);

  assert_tx_reset_idle_R9: assert property (@(posedge clk)
    tx_rst |=> !gen_valid);
endmodule

bind incpat_bist incpat_bist_sva #(.BYTE_W(BYTE_W), .LANES(LANES)) u_sva (.*);

// File: tb/incpat_bist_bench.sv
`timescale 1ns/1ps
module incpat_bist_bench;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic tx_rst = 1'b1, rx_rst = 1'b1;
  logic gen_valid, gen_ready = 1'b0;
  logic [15:0] gen_data;
  logic chk_valid, chk_ready, chk_err, chk_done;
  logic [15:0] chk_data;

  logic direct = 1'b1;
  logic drv_v = 1'b0;
  logic [15:0] drv_d = '0;
  logic [15:0] inj = '0;
  logic [LAT-1:0] pv;
  logic [15:0] pd [LAT];

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    pv[0] <= gen_valid && gen_ready;
    pd[0] <= gen_data ^ inj;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
  end

  assign chk_valid = direct ? drv_v : pv[LAT-1];
  assign chk_data  = direct ? drv_d : pd[LAT-1];

  incpat_bist u_incpat_bist (
    .clk(clk), .tx_rst(tx_rst), .rx_rst(rx_rst),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_data(gen_data),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_data(chk_data),
    .chk_err(chk_err), .chk_done(chk_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic v, input logic [15:0] w);
    @(negedge clk);
    drv_v = v; drv_d = w;
    @(negedge clk);
    drv_v = 1'b0;
  endtask

  task automatic reset_rx();
    @(negedge clk); rx_rst = 1'b1;
    @(negedge clk); rx_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic reset_tx();
    @(negedge clk); tx_rst = 1'b1;
    @(negedge clk); tx_rst = 1'b0;
  endtask

  task automatic t_reset_state();
    cycles(3);
    check("R9 gen_valid low in reset", gen_valid, 0);
    check("R9 chk_ready low in reset", chk_ready, 0);
    check("R8 err clear", chk_err, 0);
    check("R8 done clear", chk_done, 0);
    tx_rst = 1'b0; rx_rst = 1'b0;
    @(negedge clk);
    check("R9 gen_valid after reset", gen_valid, 1);
    check("R9 chk_ready after reset", chk_ready, 1);
    check("R1 first word", gen_data, 32'h0100);
  endtask

  task automatic t_backpressure();
    gen_ready = 1'b0;
    cycles(4);
    check("R2 hold under stall", gen_data, 32'h0100);
    gen_ready = 1'b1; @(negedge clk); gen_ready = 1'b0;
    check("R2 one step", gen_data, 32'h0302);
    gen_ready = 1'b1; cycles(126); gen_ready = 1'b0;
    check("R1 last word before wrap", gen_data, 32'hFFFE);
    gen_ready = 1'b1; @(negedge clk); gen_ready = 1'b0;
    check("R2 wrap", gen_data, 32'h0100);
  endtask

  task automatic t_sync_and_count();
    reset_rx();
    direct = 1'b1;
    send(1'b0, 16'h0403);
    send(1'b1, 16'h0505);
    send(1'b1, 16'h1234);
    check("R4 junk ignored while hunting", chk_err, 0);
    send(1'b1, 16'h8180);
    send(1'b0, 16'h0000);
    check("R3 invalid word ignored", chk_err, 0);
    for (int k = 1; k < 127; k++) begin
      logic [7:0] b;
      b = 8'h80 + 8'(2 * k);
      send(1'b1, {b + 8'd1, b});
    end
    check("R6 done low after 127 words", chk_done, 0);
    check("R6 err low after 127 words", chk_err, 0);
    send(1'b1, 16'h7F7E);
    check("R6 done after 128 words", chk_done, 1);
    check("R6 err stays low", chk_err, 0);
    send(1'b1, 16'h8180);
    check("R7 done sticky", chk_done, 1);
  endtask

  task automatic t_mismatch();
    reset_rx();
    send(1'b1, 16'h1110);
    send(1'b1, 16'h1312);
    send(1'b1, 16'h1514);
    check("R5 no err on match", chk_err, 0);
    send(1'b1, 16'h1716);
    send(1'b1, 16'h1B1A);
    check("R5 err on mismatch", chk_err, 1);
    check("R5 done on mismatch", chk_done, 1);
    send(1'b1, 16'h1D1C);
    check("R7 err frozen", chk_err, 1);
    reset_rx();
    check("R8 rx reset clears err", chk_err, 0);
    check("R8 rx reset clears done", chk_done, 0);
  endtask

  task automatic t_loop_pass();
    direct = 1'b0;
    reset_tx();
    gen_ready = 1'b0;
    reset_rx();
    gen_ready = 1'b1;
    cycles(60);
    check("R6 loop not done early", chk_done, 0);
    cycles(200);
    check("R6 loop done", chk_done, 1);
    check("R6 loop no err", chk_err, 0);
  endtask

  task automatic t_loop_inject();
    gen_ready = 1'b0;
    reset_rx();
    gen_ready = 1'b1;
    cycles(20);
    check("R5 loop clean", chk_err, 0);
    inj = 16'h0010; @(negedge clk); inj = '0;
    cycles(LAT + 3);
    check("R5 injected err", chk_err, 1);
    check("R5 injected done", chk_done, 1);
    reset_tx();
    cycles(10);
    check("R8 tx reset keeps err", chk_err, 1);
    check("R8 tx reset keeps done", chk_done, 1);
  endtask

  task automatic t_tx_restart();
    gen_ready = 1'b0;
    reset_rx();
    gen_ready = 1'b1;
    cycles(30);
    reset_tx();
    cycles(LAT + 4);
    check("R8 tx restart seen as mismatch", chk_err, 1);
  endtask

  initial begin
    t_reset_state();
    t_backpressure();
    t_sync_and_count();
    t_mismatch();
    t_loop_pass();
    t_loop_inject();
    t_tx_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule